// File: doc/BRIEF.md
# Serial port sample FIFO and service-request controller

This block sits between a processor-side register port and the serial engine of a synchronous serial port. It holds one transmit queue and one receive queue of audio or data samples. Software, or a DMA engine, fills the transmit queue and drains the receive queue through a single data address; repeated accesses to that address walk through the queue. The serial engine takes transmit samples and delivers receive samples through simple one-cycle strobes.

Two service-request outputs tell the DMA or interrupt logic when a queue needs attention. The transmit request fires when the transmit queue runs low. The receive request fires when the receive queue fills up. Each threshold field is stored as the true level minus one. The engine is never held back. When a queue cannot keep up, a sample is lost or zero is sent, and a sticky error flag records the event. A status register reports both fill counts, full and empty flags, and the three error flags.

Top module: `serial_fifo_ctrl`

## Requirements
- R1: After reset, the control word reads 0 and the port is disabled. Status reads 0x0005_0000: both counts are 0, both empty flags are 1, both full flags are 0 and all error flags are 0. Both requests are low and txData is 0.
- R2: Register map: address 0 is control, address 1 is status, address 2 is data. Control has enable in bit 0, the transmit threshold in bits 7:4 and the receive threshold in bits 11:8. Status has the TX count in bits 4:0 and the RX count in bits 12:8. Bit 16 is TX empty, 17 is TX full, 18 is RX empty and 19 is RX full. Bit 20 is TX overflow, 21 is TX underrun and 22 is RX overrun.
- R3: txReq is high exactly when the port is enabled and the TX count is at most the transmit threshold plus one.
- R4: rxReq is high exactly when the port is enabled and the RX count is at least the receive threshold plus one.
- R5: Each queue holds 16 samples of 32 bits in first-in first-out order. The full flag is set at 16 samples.
- R6: A data write to a full TX queue is dropped, leaves the count at 16 and sets the TX overflow flag.
- R7: An engine pop from an empty TX queue drives txData to 0, leaves the count at 0 and sets the TX underrun flag.
- R8: An engine push into a full RX queue is dropped, leaves the stored samples unchanged and sets the RX overrun flag.
- R9: A data read from an empty RX queue returns the last sample read successfully, or 0 if none has been read since reset. The read leaves the count unchanged.
- R10: Error flags stay set until a status write with a 1 in the flag's bit position. Writing 0 to a flag's bit leaves that flag unchanged.
- R11: While enable is 0, both queues are emptied one cycle after enable clears. Data writes, data reads that would pop a sample, and engine strobes have no effect. No error flag is set, both requests are low and txData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of address 2 pops the RX queue) |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the cycle of the read strobe |
| txPop | input | 1 | Engine takes one transmit sample |
| txData | output | 32 | Transmit sample at the head of the queue (0 when empty) |
| rxPush | input | 1 | Engine delivers one receive sample |
| rxData | input | 32 | Receive sample from the engine |
| txReq | output | 1 | Transmit service request |
| rxReq | output | 1 | Receive service request |

## Verification
A wrong count or a wrong pointer shows up at the ports within one access. The status count moves off its expected value, a request flips at the wrong fill level, or a drained sample comes out of order. The threshold sweeps step each queue through every fill level from 0 to 16 for every threshold value, so an off-by-one in the offset encoding shows up at the exact level where it occurs. A flag that is not sticky, or that is cleared by the wrong bit, appears in the next status read. A flush that is missed appears one cycle after disable, as a non-zero count or a raised request.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned POS_TXTHR   = 4;
  localparam int unsigned POS_RXTHR   = 8;
  localparam int unsigned POS_TXCNT   = 0;
  localparam int unsigned POS_RXCNT   = 8;
  localparam int unsigned BIT_TXEMPTY = 16;
  localparam int unsigned BIT_TXFULL  = 17;
  localparam int unsigned BIT_RXEMPTY = 18;
  localparam int unsigned BIT_RXFULL  = 19;
  localparam int unsigned BIT_TXOVF   = 20;
  localparam int unsigned BIT_TXUND   = 21;
  localparam int unsigned BIT_RXOVR   = 22;

  typedef struct packed {
    logic run;
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } sfcStrobe_t;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wdata;
  end

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfcStrobe_t        strobe,
  input  logic [DATA_W-1:0] txWdata,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxReadData,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty
);
  logic [DATA_W-1:0] txHead;
  logic [DATA_W-1:0] rxHead;
  logic [DATA_W-1:0] lastRead;

  sfc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strobe.flush),
    .push  (strobe.txPush),
    .pop   (strobe.txPop),
    .wdata (txWdata),
    .head  (txHead),
    .count (txCount),
    .full  (txFull),
    .empty (txEmpty)
  );

  sfc_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strobe.flush),
    .push  (strobe.rxPush),
    .pop   (strobe.rxPop),
    .wdata (rxData),
    .head  (rxHead),
    .count (rxCount),
    .full  (rxFull),
    .empty (rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastRead <= '0;
    else if (strobe.rxPop) lastRead <= rxHead;
  end

  assign rxReadData = rxEmpty ? lastRead : rxHead;
  assign txData     = (strobe.run && !txEmpty) ? txHead : '0;

  // R9: a pop always hands out the sample that is remembered for later empty reads
  assert_last_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxPop |=> (lastRead == $past(rxReadData)));
endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPopIn,
  input  logic              rxPushIn,
  input  logic [DATA_W-1:0] rxReadData,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  output sfcStrobe_t        strobe,
  output logic              txReq,
  output logic              rxReq
);
  logic          enable;
  logic [AW-1:0] txThr;
  logic [AW-1:0] rxThr;
  logic          errTxOvf;
  logic          errTxUnd;
  logic          errRxOvr;
  logic          unusedWdata;

  logic wrCtrl, wrStat, wrData, rdData;
  logic setTxOvf, setTxUnd, setRxOvr;
  logic [CW-1:0] txLevel, rxLevel;

  assign unusedWdata = ^regWdata;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat = regWrEn && (regAddr == ADDR_STAT);
  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);

  always_comb begin
    strobe.run    = enable;
    strobe.flush  = !enable;
    strobe.txPush = enable && wrData   && !txFull;
    strobe.txPop  = enable && txPopIn  && !txEmpty;
    strobe.rxPush = enable && rxPushIn && !rxFull;
    strobe.rxPop  = enable && rdData   && !rxEmpty;
  end

  assign setTxOvf = enable && wrData   && txFull;
  assign setTxUnd = enable && txPopIn  && txEmpty;
  assign setRxOvr = enable && rxPushIn && rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      txThr  <= '0;
      rxThr  <= '0;
    end else if (wrCtrl) begin
      enable <= regWdata[BIT_EN];
      txThr  <= regWdata[POS_TXTHR +: AW];
      rxThr  <= regWdata[POS_RXTHR +: AW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errTxOvf <= 1'b0;
      errTxUnd <= 1'b0;
      errRxOvr <= 1'b0;
    end else begin
      errTxOvf <= setTxOvf || (errTxOvf && !(wrStat && regWdata[BIT_TXOVF]));
      errTxUnd <= setTxUnd || (errTxUnd && !(wrStat && regWdata[BIT_TXUND]));
      errRxOvr <= setRxOvr || (errRxOvr && !(wrStat && regWdata[BIT_RXOVR]));
    end
  end

  assign txLevel = CW'(txThr) + CW'(1);
  assign rxLevel = CW'(rxThr) + CW'(1);
  assign txReq   = enable && (txCount <= txLevel);
  assign rxReq   = enable && (rxCount >= rxLevel);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[BIT_EN]           = enable;
        regRdata[POS_TXTHR +: AW]  = txThr;
        regRdata[POS_RXTHR +: AW]  = rxThr;
      end
      ADDR_STAT: begin
        regRdata[POS_TXCNT +: CW]  = txCount;
        regRdata[POS_RXCNT +: CW]  = rxCount;
        regRdata[BIT_TXEMPTY]      = txEmpty;
        regRdata[BIT_TXFULL]       = txFull;
        regRdata[BIT_RXEMPTY]      = rxEmpty;
        regRdata[BIT_RXFULL]       = rxFull;
        regRdata[BIT_TXOVF]        = errTxOvf;
        regRdata[BIT_TXUND]        = errTxUnd;
        regRdata[BIT_RXOVR]        = errRxOvr;
      end
      ADDR_DATA: regRdata = rxReadData;
      default:   regRdata = '0;
    endcase
  end

  assert_tx_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrData && txFull) |=> (errTxOvf && txFull));
  assert_tx_underrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txPopIn && txEmpty) |=> errTxUnd);
  assert_rx_overrun_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rxPushIn && rxFull) |=> (errRxOvr && rxFull));
  assert_empty_read_still_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && rxEmpty && !rxPushIn) |=> (rxCount == '0));
  assert_sticky_rxovr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errRxOvr && !(wrStat && regWdata[BIT_RXOVR])) |=> errRxOvr);
  assert_sticky_txund_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errTxUnd && !(wrStat && regWdata[BIT_TXUND])) |=> errTxUnd);
  assert_idle_no_error_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !errTxUnd) |=> !errTxUnd);
endmodule

// File: rtl/serial_fifo_ctrl.sv
module serial_fifo_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  output logic              txReq,
  output logic              rxReq
);
  sfcStrobe_t        strobe;
  logic [DATA_W-1:0] rxReadData;
  logic [CW-1:0]     txCount, rxCount;
  logic              txFull, txEmpty, rxFull, rxEmpty;

  sfc_control #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .txPopIn    (txPop),
    .rxPushIn   (rxPush),
    .rxReadData (rxReadData),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty),
    .strobe     (strobe),
    .txReq      (txReq),
    .rxReq      (rxReq)
  );

  sfc_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txWdata    (regWdata),
    .rxData     (rxData),
    .txData     (txData),
    .rxReadData (rxReadData),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .rxEmpty    (rxEmpty)
  );
endmodule

// File: tb/serial_fifo_ctrl_bench.sv
module serial_fifo_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txPop = 1'b0;
  logic [31:0] txData;
  logic        rxPush = 1'b0;
  logic [31:0] rxData = '0;
  logic        txReq, rxReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_fifo_ctrl u_serial_fifo_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txData(txData), .rxPush(rxPush), .rxData(rxData),
    .txReq(txReq), .rxReq(rxReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic enginePop(output logic [31:0] d);
    @(negedge clk);
    txPop = 1'b1;
    #1 d = txData;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic enginePush(input logic [31:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxData = d;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  function automatic logic [31:0] txStat(input int n);
    return 32'(n) | ((n == 16) ? 32'h2_0000 : 0) | ((n == 0) ? 32'h1_0000 : 0) | 32'h4_0000;
  endfunction

  function automatic logic [31:0] rxStat(input int n);
    return (32'(n) << 8) | ((n == 16) ? 32'h8_0000 : 0) | ((n == 0) ? 32'h4_0000 : 0) | 32'h1_0000;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, d); chk("R1 ctrl", d, 32'h0);
    regRead(2'd1, d); chk("R1 status", d, 32'h0005_0000);
    chk("R1 txReq", {31'b0, txReq}, 0);
    chk("R1 rxReq", {31'b0, rxReq}, 0);
    chk("R1 txData", txData, 0);

    // R9 empty read before any pop returns 0
    regWrite(2'd0, 32'h1);
    regRead(2'd2, d); chk("R9 empty read after reset", d, 0);
    regRead(2'd1, d); chk("R9 count unchanged", d, 32'h0005_0000);
    regRead(2'd0, d); chk("R2 ctrl readback", d, 32'h1);

    // R3 R5 TX threshold sweep over every threshold and level
    for (int t = 0; t < 16; t++) begin
      regWrite(2'd0, 32'h0);
      @(negedge clk);
      regWrite(2'd0, (32'(t) << 4) | 32'h1);
      regRead(2'd1, d); chk("R2 tx status level 0", d, txStat(0));
      chk("R3 txReq level 0", {31'b0, txReq}, 1);
      for (int n = 1; n <= 16; n++) begin
        regWrite(2'd2, 32'hA500_0000 + 32'(t * 256 + n));
        regRead(2'd1, d); chk("R5 tx status", d, txStat(n));
        chk("R3 txReq", {31'b0, txReq}, {31'b0, n <= t + 1});
      end
    end

    // R6 write to full TX
    regWrite(2'd2, 32'hFFFF_FFFF);
    regRead(2'd1, d); chk("R6 overflow status", d, txStat(16) | 32'h10_0000);

    // R5 drain order
    for (int n = 1; n <= 16; n++) begin
      enginePop(d); chk("R5 tx order", d, 32'hA500_0000 + 32'(15 * 256 + n));
    end
    // R7 underrun
    enginePop(d); chk("R7 underrun data", d, 0);
    regRead(2'd1, d); chk("R7 underrun status", d, txStat(0) | 32'h30_0000);

    // R10 write-one-to-clear, per bit
    regWrite(2'd1, 32'h0);
    regRead(2'd1, d); chk("R10 zero write keeps flags", d, txStat(0) | 32'h30_0000);
    regWrite(2'd1, 32'h10_0000);
    regRead(2'd1, d); chk("R10 clear overflow only", d, txStat(0) | 32'h20_0000);
    regWrite(2'd1, 32'h20_0000);
    regRead(2'd1, d); chk("R10 clear underrun", d, txStat(0));

    // R4 R5 RX threshold sweep
    for (int r = 0; r < 16; r++) begin
      regWrite(2'd0, 32'h0);
      @(negedge clk);
      regWrite(2'd0, (32'(r) << 8) | 32'h1);
      chk("R4 rxReq level 0", {31'b0, rxReq}, 0);
      for (int n = 1; n <= 16; n++) begin
        enginePush(32'h5A00_0000 + 32'(r * 256 + n));
        regRead(2'd1, d); chk("R5 rx status", d, rxStat(n));
        chk("R4 rxReq", {31'b0, rxReq}, {31'b0, n >= r + 1});
      end
    end

    // R8 push into full RX
    enginePush(32'hDEAD_BEEF);
    regRead(2'd1, d); chk("R8 overrun status", d, rxStat(16) | 32'h40_0000);
    for (int n = 1; n <= 16; n++) begin
      regRead(2'd2, d); chk("R5 R8 rx order", d, 32'h5A00_0000 + 32'(15 * 256 + n));
    end
    // R9 empty reads repeat last value
    regRead(2'd2, d); chk("R9 repeat 1", d, 32'h5A00_0000 + 32'(15 * 256 + 16));
    regRead(2'd2, d); chk("R9 repeat 2", d, 32'h5A00_0000 + 32'(15 * 256 + 16));
    regRead(2'd1, d); chk("R9 status", d, rxStat(0) | 32'h40_0000);
    regWrite(2'd1, 32'h70_0000);

    // R11 disable flushes and ignores traffic
    regWrite(2'd0, 32'h31);
    regWrite(2'd2, 32'h11); regWrite(2'd2, 32'h22); regWrite(2'd2, 32'h33);
    enginePush(32'h44); enginePush(32'h55);
    regRead(2'd1, d); chk("R11 pre-disable", d, 32'h0000_0203);
    regWrite(2'd0, 32'h0);
    @(negedge clk);
    regRead(2'd1, d); chk("R11 flushed", d, 32'h0005_0000);
    chk("R11 txReq low", {31'b0, txReq}, 0);
    regWrite(2'd2, 32'h66);
    enginePush(32'h77);
    enginePop(d); chk("R11 txData zero", d, 0);
    regRead(2'd2, d);
    regRead(2'd1, d); chk("R11 ignored traffic", d, 32'h0005_0000);
    chk("R11 rxReq low", {31'b0, rxReq}, 0);
    regWrite(2'd0, 32'h1);
    regRead(2'd1, d); chk("R11 re-enable empty", d, 32'h0005_0000);

    finishRun();
  end
endmodule